// File: doc/BRIEF.md
# Pattern-Driven Array Address Generator

This block turns loop counter values into word addresses for a two-dimensional array that sits in on-chip memory. A small bank of address contexts holds the whole access recipe. For each axis it picks where the index comes from, and it adds and shifts that index. It also holds a row length (a power of two), a base word and the memory port the access is issued on. A one-cycle request strobe names a context. The block samples the current loop counters and issues one registered address, marked by a single-cycle valid.

The row axis yields `((idx_r + off_r) << sh_r) + add_r` and the column axis the same form with its own constants. The linear address is `base + (row_term << row_log2) + col_term`, taken modulo the memory depth. Either axis may take a per-context constant in place of a loop counter. An override value given with the request replaces that constant for one access, so an unrolled loop body can step through neighbouring elements with a single context.

A context may be marked indirect, as in `A[B[i]]`. The first issue is then a fetch of the index word from the index array, addressed through the second base. The block waits for the memory to return that word. The cycle after the word arrives, it issues `base + word` on the data port. Any computed address that reaches or passes the memory depth sets an error flag that stays set until reset.

Top module: `pattern_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `busy` and `err` are 0.
- R2: A request to a direct context while `busy` is 0 gives `addr_valid`=1 on the next cycle, for that one cycle only, with `addr` = (base + (row_term << row_log2) + col_term) mod MEM_DEPTH, `addr_port` = the context's data port and `addr_fetch` = 0. The term is ((index + off) << sh) + add.
- R3: An axis source code below NUM_LOOPS (4) selects loop counter lane `code`, where lane n is `loop_idx[8n+7:8n]`. Any other code (4 to 7) selects the context's stored constant for that axis.
- R4: When `ovr_en` is 1 with the request, `ovr_val` replaces the stored constant for every axis whose source is a constant. Axes that read a loop counter are unaffected.
- R5: A request to an indirect context issues, one cycle later, a fetch address from the index base with `addr_fetch`=1 on the index port, and raises `busy`. On the cycle after `rd_valid`, it issues `addr` = (base + `rd_data`) mod MEM_DEPTH with `addr_fetch`=0 on the data port, and `busy` falls.
- R6: While `busy` is 1, requests are ignored and no address is issued. `rd_valid` while `busy` is 0 is ignored.
- R7: When an issued address before wrapping is MEM_DEPTH (1024) or more, `err` becomes 1 with that issue and stays 1 until reset, while `addr` shows the wrapped value.
- R8: Each context keeps its own settings. Writing one context does not change the addresses that another produces.
- R9: With no request and no returned word, `addr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write the context selected by `cfg_sel` |
| cfg_sel | input | 2 | Context number to write |
| cfg_word | input | CTX_BITS | Packed context record (`ctx_t`) |
| loop_idx | input | 32 | Four 8-bit loop counter lanes |
| req | input | 1 | Issue request strobe |
| req_ctx | input | 2 | Context used by the request |
| ovr_en | input | 1 | Apply the constant override to this request |
| ovr_val | input | 8 | Override value |
| rd_valid | input | 1 | Index word is returned this cycle |
| rd_data | input | 12 | Returned index word |
| addr_valid | output | 1 | An address is issued this cycle |
| addr | output | 10 | Issued word address |
| addr_port | output | 2 | Memory port for the address |
| addr_fetch | output | 1 | 1 for an index fetch, 0 for a data access |
| busy | output | 1 | Waiting for an index word |
| err | output | 1 | Sticky out-of-range flag |

## Verification
The hardest state to reach from the ports is a request that arrives while an indirect access is still waiting for its index word. Reaching it takes a context marked indirect, an issued fetch and a memory that is slow to answer. The bench keeps the index word back for a random number of cycles. On each of those cycles it raises `req` toward a random context and checks that nothing is issued. It also raises `rd_valid` when no access is pending, to show that a stray return word is dropped.

// File: rtl/agen_pkg.sv
package agen_pkg;

    localparam int IDX_W  = 8;   // loop counter lane width
    localparam int OFS_W  = 8;   // offset / addend width
    localparam int SH_W   = 3;   // shift amount width
    localparam int SRC_W  = 3;   // axis source code width
    localparam int PORT_W = 2;   // memory port number width
    localparam int BASE_W = 12;  // base address field width
    localparam int DATA_W = 12;  // returned index word width
    localparam int WIDE_W = 28;  // unwrapped address width

    typedef logic [PORT_W-1:0] port_t;
    typedef logic [SRC_W-1:0]  src_t;

    typedef struct packed {
        logic [OFS_W-1:0] off;
        logic [SH_W-1:0]  sh;
        logic [OFS_W-1:0] add;
    } term_k_t;

    typedef struct packed {
        logic              indirect;
        port_t             data_port;
        port_t             idx_port;
        src_t              row_src;
        src_t              col_src;
        term_k_t           row_k;
        term_k_t           col_k;
        logic [SH_W-1:0]   row_log2;
        logic [BASE_W-1:0] base;
        logic [BASE_W-1:0] ibase;
        logic [IDX_W-1:0]  row_const;
        logic [IDX_W-1:0]  col_const;
    } ctx_t;

    localparam int CTX_BITS = $bits(ctx_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } agen_state_e;

    typedef struct packed {
        logic [WIDE_W-1:0] wide;
        port_t             port;
        logic              fetch;
    } issue_t;

    function automatic logic [WIDE_W-1:0] axis_term(input logic [IDX_W-1:0] idx,
                                                    input term_k_t k);
        logic [WIDE_W-1:0] s;
        s = WIDE_W'(idx) + WIDE_W'(k.off);
        return (s << k.sh) + WIDE_W'(k.add);
    endfunction

endpackage

// File: rtl/agen_ctx_bank.sv
module agen_ctx_bank
    import agen_pkg::*;
#(
    parameter int NUM_CTX = 4,
    localparam int SEL_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  ctx_t             wdata,
    input  logic [SEL_W-1:0] rsel,
    output ctx_t             rdata
);

    ctx_t slots [NUM_CTX];

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (we && (int'(wsel) == g)) begin
                slots[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < NUM_CTX; n++) begin
            if (int'(rsel) == n) rdata = slots[n];
        end
    end

endmodule

// File: rtl/agen_term.sv
module agen_term
    import agen_pkg::*;
#(
    parameter int NUM_LOOPS = 4
) (
    input  logic [NUM_LOOPS*IDX_W-1:0] loop_idx,
    input  src_t                       src,
    input  logic [IDX_W-1:0]           konst,
    input  logic                       ovr_en,
    input  logic [IDX_W-1:0]           ovr_val,
    input  term_k_t                    k,
    output logic [WIDE_W-1:0]          term
);

    logic [IDX_W-1:0] lanes [NUM_LOOPS];
    logic [IDX_W-1:0] picked;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_lane
        assign lanes[g] = loop_idx[g*IDX_W +: IDX_W];
    end

    always_comb begin
        picked = ovr_en ? ovr_val : konst;
        for (int n = 0; n < NUM_LOOPS; n++) begin
            if (int'(src) == n) picked = lanes[n];
        end
    end

    assign term = axis_term(picked, k);

endmodule

// File: rtl/agen_combine.sv
module agen_combine
    import agen_pkg::*;
(
    input  logic [WIDE_W-1:0] row_term,
    input  logic [WIDE_W-1:0] col_term,
    input  logic [SH_W-1:0]   row_log2,
    input  logic [BASE_W-1:0] base,
    output logic [WIDE_W-1:0] lin
);

    assign lin = WIDE_W'(base) + (row_term << row_log2) + col_term;

endmodule

// File: rtl/pattern_addr_gen.sv
module pattern_addr_gen
    import agen_pkg::*;
#(
    parameter int NUM_CTX   = 4,
    parameter int NUM_LOOPS = 4,
    parameter int MEM_DEPTH = 1024,
    localparam int CSEL_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int AW     = $clog2(MEM_DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [CSEL_W-1:0]          cfg_sel,
    input  logic [CTX_BITS-1:0]        cfg_word,
    input  logic [NUM_LOOPS*IDX_W-1:0] loop_idx,
    input  logic                       req,
    input  logic [CSEL_W-1:0]          req_ctx,
    input  logic                       ovr_en,
    input  logic [IDX_W-1:0]           ovr_val,
    input  logic                       rd_valid,
    input  logic [DATA_W-1:0]          rd_data,
    output logic                       addr_valid,
    output logic [AW-1:0]              addr,
    output logic [PORT_W-1:0]          addr_port,
    output logic                       addr_fetch,
    output logic                       busy,
    output logic                       err
);

    ctx_t              cur;
    logic [WIDE_W-1:0] terms [2];
    logic [WIDE_W-1:0] lin;
    agen_state_e       state_q;
    logic [BASE_W-1:0] pend_base_q;
    port_t             pend_port_q;
    issue_t            nxt;
    logic              issue;
    logic              valid_q, fetch_q, err_q;
    logic [AW-1:0]     addr_q;
    port_t             port_q;

    agen_ctx_bank #(.NUM_CTX(NUM_CTX)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wsel  (cfg_sel),
        .wdata (ctx_t'(cfg_word)),
        .rsel  (req_ctx),
        .rdata (cur)
    );

    // axis 0 = row, axis 1 = column
    for (genvar g = 0; g < 2; g++) begin : g_axis
        agen_term #(.NUM_LOOPS(NUM_LOOPS)) u_term (
            .loop_idx (loop_idx),
            .src      ((g == 0) ? cur.row_src   : cur.col_src),
            .konst    ((g == 0) ? cur.row_const : cur.col_const),
            .ovr_en   (ovr_en),
            .ovr_val  (ovr_val),
            .k        ((g == 0) ? cur.row_k     : cur.col_k),
            .term     (terms[g])
        );
    end

    agen_combine u_comb (
        .row_term (terms[0]),
        .col_term (terms[1]),
        .row_log2 (cur.row_log2),
        .base     (cur.indirect ? cur.ibase : cur.base),
        .lin      (lin)
    );

    always_comb begin
        issue = 1'b0;
        nxt   = '0;
        if (state_q == ST_IDLE) begin
            if (req) begin
                issue     = 1'b1;
                nxt.wide  = lin;
                nxt.port  = cur.indirect ? cur.idx_port : cur.data_port;
                nxt.fetch = cur.indirect;
            end
        end else if (rd_valid) begin
            issue     = 1'b1;
            nxt.wide  = WIDE_W'(pend_base_q) + WIDE_W'(rd_data);
            nxt.port  = pend_port_q;
            nxt.fetch = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            pend_base_q <= '0;
            pend_port_q <= '0;
            valid_q     <= 1'b0;
            addr_q      <= '0;
            port_q      <= '0;
            fetch_q     <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            valid_q <= issue;
            if (issue) begin
                addr_q  <= nxt.wide[AW-1:0];
                port_q  <= nxt.port;
                fetch_q <= nxt.fetch;
                if (nxt.wide >= WIDE_W'(MEM_DEPTH)) err_q <= 1'b1;
            end
            case (state_q)
                ST_IDLE: if (req && cur.indirect) begin
                    state_q     <= ST_WAIT;
                    pend_base_q <= cur.base;
                    pend_port_q <= cur.data_port;
                end
                default: if (rd_valid) state_q <= ST_IDLE;
            endcase
        end
    end

    assign addr_valid = valid_q;
    assign addr       = addr_q;
    assign addr_port  = port_q;
    assign addr_fetch = fetch_q;
    assign busy       = (state_q == ST_WAIT);
    assign err        = err_q;

    AST_IDLE_REQ_ISSUES: assert property (@(posedge clk) disable iff (rst)
        (!busy && req) |=> addr_valid);                                   // R2
    AST_FETCH_MEANS_WAIT: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_fetch) |-> busy);                             // R5
    AST_RETURN_ISSUES_DATA: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_valid) |=> (addr_valid && !addr_fetch && !busy));     // R5
    AST_WAIT_IS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_valid) |=> !addr_valid);                             // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                     // R7
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        (!req && !rd_valid) |=> !addr_valid);                             // R9

endmodule

// File: tb/sim_pattern_addr_gen.sv
`timescale 1ns/1ps
module sim_pattern_addr_gen;
    import agen_pkg::*;

    localparam int NCTX  = 4;
    localparam int NLOOP = 4;
    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [CTX_BITS-1:0] cfg_word = '0;
    logic [NLOOP*IDX_W-1:0] loop_idx = '0;
    logic req = 1'b0;
    logic [1:0] req_ctx = '0;
    logic ovr_en = 1'b0;
    logic [IDX_W-1:0] ovr_val = '0;
    logic rd_valid = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic addr_valid;
    logic [9:0] addr;
    logic [PORT_W-1:0] addr_port;
    logic addr_fetch, busy, err;

    int n_tests = 0;
    int n_fail  = 0;
    ctx_t shadow [NCTX];
    int li [NLOOP];
    bit exp_err = 0;

    always #4 clk = ~clk;   // 125 MHz

    pattern_addr_gen u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
        .loop_idx(loop_idx), .req(req), .req_ctx(req_ctx), .ovr_en(ovr_en),
        .ovr_val(ovr_val), .rd_valid(rd_valid), .rd_data(rd_data),
        .addr_valid(addr_valid), .addr(addr), .addr_port(addr_port),
        .addr_fetch(addr_fetch), .busy(busy), .err(err)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint pick(int src, int konst, bit oe, int ov);
        if (src < NLOOP) return li[src];
        return oe ? ov : konst;
    endfunction

    function automatic longint model_term(int idx, term_k_t k);
        return ((longint'(idx) + k.off) << k.sh) + k.add;
    endfunction

    function automatic longint model_lin(ctx_t c, bit oe, int ov);
        longint r, cl, b;
        r  = model_term(int'(pick(c.row_src, c.row_const, oe, ov)), c.row_k);
        cl = model_term(int'(pick(c.col_src, c.col_const, oe, ov)), c.col_k);
        b  = c.indirect ? c.ibase : c.base;
        return b + (r << c.row_log2) + cl;
    endfunction

    task automatic set_loops(int a, int b, int c, int d);
        li[0] = a; li[1] = b; li[2] = c; li[3] = d;
        for (int n = 0; n < NLOOP; n++) loop_idx[n*IDX_W +: IDX_W] = IDX_W'(li[n]);
    endtask

    task automatic write_ctx(int s, ctx_t c);
        cfg_we = 1'b1; cfg_sel = 2'(s); cfg_word = c;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow[s] = c;
    endtask

    // Issue on context s; for indirect contexts, hold the word for gap cycles.
    task automatic issue(string tag, int s, bit oe, int ov, int gap, int word);
        longint w;
        ctx_t c;
        c = shadow[s];
        req = 1'b1; req_ctx = 2'(s); ovr_en = oe; ovr_val = IDX_W'(ov);
        @(negedge clk);
        req = 1'b0; ovr_en = 1'b0;
        w = model_lin(c, oe, ov);
        if (w >= DEPTH) exp_err = 1;
        chk({tag, " valid"}, addr_valid, 1);
        chk({tag, " addr"}, addr, w % DEPTH);
        chk({tag, " port"}, addr_port, c.indirect ? c.idx_port : c.data_port);
        chk({tag, " fetch"}, addr_fetch, c.indirect);
        chk({tag, " err R7"}, err, exp_err);
        if (c.indirect) begin
            chk({tag, " busy R5"}, busy, 1);
            for (int g = 0; g < gap; g++) begin
                req = 1'b1; req_ctx = 2'($urandom_range(0, NCTX-1));
                @(negedge clk);
                req = 1'b0;
                chk("R6 req ignored while waiting", addr_valid, 0);
                chk("R6 still busy", busy, 1);
            end
            rd_valid = 1'b1; rd_data = DATA_W'(word);
            @(negedge clk);
            rd_valid = 1'b0;
            w = longint'(c.base) + word;
            if (w >= DEPTH) exp_err = 1;
            chk("R5 data valid", addr_valid, 1);
            chk("R5 data addr", addr, w % DEPTH);
            chk("R5 data port", addr_port, c.data_port);
            chk("R5 data fetch flag", addr_fetch, 0);
            chk("R5 busy released", busy, 0);
        end
    endtask

    function automatic ctx_t rand_ctx();
        ctx_t c;
        c = '0;
        c.indirect  = ($urandom_range(0, 3) == 0);
        c.data_port = PORT_W'($urandom_range(0, 3));
        c.idx_port  = PORT_W'($urandom_range(0, 3));
        c.row_src   = SRC_W'($urandom_range(0, 7));
        c.col_src   = SRC_W'($urandom_range(0, 7));
        c.row_k.off = OFS_W'($urandom_range(0, 3));
        c.row_k.sh  = SH_W'($urandom_range(0, 1));
        c.row_k.add = OFS_W'($urandom_range(0, 3));
        c.col_k.off = OFS_W'($urandom_range(0, 3));
        c.col_k.sh  = SH_W'($urandom_range(0, 1));
        c.col_k.add = OFS_W'($urandom_range(0, 3));
        c.row_log2  = SH_W'($urandom_range(0, 3));
        c.base      = BASE_W'($urandom_range(0, 127));
        c.ibase     = BASE_W'($urandom_range(0, 127));
        c.row_const = IDX_W'($urandom_range(0, 7));
        c.col_const = IDX_W'($urandom_range(0, 7));
        return c;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        ctx_t c;
        void'($urandom(32'd2024));
        for (int n = 0; n < NCTX; n++) shadow[n] = '0;
        set_loops(0, 0, 0, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 valid after reset", addr_valid, 0);
        chk("R1 busy after reset", busy, 0);
        chk("R1 err after reset", err, 0);

        // Matrix example: A at 0, B at 256, 16 words per row.
        c = '0; c.data_port = 2'd1; c.row_src = 3'd0; c.col_src = 3'd1;
        c.row_log2 = 3'd4; c.base = 12'd0;
        write_ctx(0, c);
        c = '0; c.data_port = 2'd2; c.row_src = 3'd1; c.col_src = 3'd7;
        c.row_log2 = 3'd4; c.base = 12'd256;
        write_ctx(1, c);
        set_loops(2, 5, 0, 0);
        issue("R2 matrix A", 0, 0, 0, 0, 0);
        chk("R2 A element 2,5", addr, 37);
        @(negedge clk);
        chk("R9 valid is one pulse", addr_valid, 0);
        issue("R2 matrix B", 1, 0, 0, 0, 0);
        chk("R4 no override", addr, 336);
        issue("R4 override", 1, 1, 3, 0, 0);
        chk("R4 override constant column", addr, 339);
        issue("R4 override ignored on loop axes", 0, 1, 6, 0, 0);
        chk("R4 loop axes unchanged", addr, 37);

        // Constant row source plus offsets and shifts.
        c = '0; c.data_port = 2'd3; c.row_src = 3'd5; c.row_const = 8'd3;
        c.col_src = 3'd2; c.row_log2 = 3'd3; c.base = 12'd10;
        c.col_k.off = 8'd1; c.col_k.sh = 3'd1; c.col_k.add = 8'd2;
        write_ctx(2, c);
        set_loops(9, 9, 6, 9);
        issue("R3 constant row", 2, 0, 0, 0, 0);
        chk("R3 constant row address", addr, 10 + 24 + 16);
        chk("R8 ctx0 unchanged after ctx2 write", model_lin(shadow[0], 0, 0), 9 * 16 + 9);
        issue("R8 ctx0 after other writes", 0, 0, 0, 0, 0);

        // Indirect access with a held-off index word.
        c = '0; c.indirect = 1'b1; c.idx_port = 2'd1; c.data_port = 2'd3;
        c.row_src = 3'd4; c.col_src = 3'd0; c.row_log2 = 3'd0;
        c.ibase = 12'd512; c.base = 12'd100;
        write_ctx(3, c);
        set_loops(7, 0, 0, 0);
        issue("R5 indirect fetch", 3, 0, 0, 3, 45);
        rd_valid = 1'b1; rd_data = 12'd5;
        @(negedge clk);
        rd_valid = 1'b0;
        chk("R6 stray return word dropped", addr_valid, 0);
        chk("R6 stray return leaves idle", busy, 0);

        // Constrained random mix.
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 7) == 0) write_ctx($urandom_range(0, NCTX-1), rand_ctx());
            set_loops($urandom_range(0, 7), $urandom_range(0, 7),
                      $urandom_range(0, 7), $urandom_range(0, 7));
            issue("R2 random", $urandom_range(0, NCTX-1), $urandom_range(0, 1),
                  $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 511));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                chk("R9 idle cycle", addr_valid, 0);
            end
        end
        chk("R7 no error in range", err, 0);

        // Out of range: wraps and sets the sticky flag.
        c = '0; c.data_port = 2'd0; c.row_src = 3'd6; c.col_src = 3'd6;
        c.col_const = 8'd50; c.base = 12'd1000;
        write_ctx(2, c);
        issue("R7 overflow", 2, 0, 0, 0, 0);
        chk("R7 wrapped address", addr, 26);
        chk("R7 err set", err, 1);
        issue("R7 err stays after good access", 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R7 err sticky idle", err, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule